// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit returns the smaller or the larger of two floating-point operands held in register-width containers. Operands may be in half, single or double precision, and each format follows the same rules. A narrow value sits in the low bits of the register. The bits above it must be all ones, which is the NaN-boxed form. Each operand is unboxed before use, and the result is boxed again before it leaves the unit.

Two NaN policies are offered. The number-preferring policy returns the ordinary operand when only one input is a NaN. The NaN-propagating policy returns the canonical NaN whenever either input is a NaN. In both policies negative zero orders below positive zero. A signaling NaN on either input raises the invalid-operation flag.

The unit has one register stage. The result and flags are captured on a cycle where the input valid is high, and the output valid follows the input valid one cycle later.

Top module: `fp_minmax_unit`

## Requirements
- R1: `in_fmt` selects the format: 0 is half (16 bits: sign, 5 exponent bits, 10 mantissa bits), 1 is single (32 bits: sign, 8, 23), and 2 or 3 is double (64 bits: sign, 11, 52). When neither operand is a NaN or a zero pair, `in_op_max`=0 returns the operand that is less than or equal to the other, and `in_op_max`=1 returns the greater one. On a tie the first operand is returned.
- R2: With `in_nan_prop`=0 and exactly one operand a NaN, the result is the other operand.
- R3: With `in_nan_prop`=0 and both operands NaN, the result is the canonical NaN of the format. The canonical NaN has a clear sign, an all-ones exponent, the top mantissa bit set and every other mantissa bit clear: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000.
- R4: With `in_nan_prop`=1 and either operand a NaN, the result is the canonical NaN of the format.
- R5: When one operand is -0 and the other is +0, min returns -0 and max returns +0, under both policies and in either operand order.
- R6: Ordering is by numeric value. This covers mixed signs and two negative operands, where the larger magnitude is the smaller number.
- R7: `out_flags` is 5 bits wide. Bit 4 (invalid) is set when either unboxed operand is a signaling NaN, meaning an all-ones exponent, a nonzero mantissa and a clear top mantissa bit. Bits 3:0 are always 0. Quiet NaNs set no flag.
- R8: A half or single operand whose bits above the format width are not all ones is treated as the canonical quiet NaN, and it raises no flag. Every result is returned with all bits above the format width set to one.
- R9: `out_valid` equals `in_valid` delayed by one cycle. A synchronous active-high `rst` clears `out_valid`, `out_res` and `out_flags` to 0.
- R10: While `in_valid` is low, `out_res` and `out_flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| in_a | input | REG_W | First operand, boxed |
| in_b | input | REG_W | Second operand, boxed |
| in_op_max | input | 1 | 0 = minimum, 1 = maximum |
| in_nan_prop | input | 1 | 0 = number-preferring, 1 = NaN-propagating |
| in_fmt | input | 2 | Format select (0 half, 1 single, 2/3 double) |
| out_valid | output | 1 | Result valid |
| out_res | output | REG_W | Boxed result |
| out_flags | output | 5 | Exception flags, bit 4 = invalid |

## Verification
The clocked assertions rely on `rst` being asserted at the first clock edge, so that each `$past` term has a defined reset history behind it. The bench holds reset high for several cycles before it applies any operand. The lane assertions assume the operand and control inputs are stable between clock edges. The bench meets this by driving every input on the falling edge and sampling the outputs on the following falling edge.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_DBL_B  = 2'd3
    } fmt_e;

    localparam int NUM_FMT = 3;
    localparam int FLAG_W  = 5;
    localparam int FLAG_NV = 4;

    function automatic int exp_bits(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int man_bits(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fpmm_unbox.sv
module fpmm_unbox #(
    parameter int REG_W = 64,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [REG_W-1:0]           raw,
    output logic [1+EXP_W+MAN_W-1:0]   val
);
    localparam int FW = 1 + EXP_W + MAN_W;
    localparam logic [FW-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    generate
        if (REG_W == FW) begin : g_full
            assign val = raw;
        end else begin : g_narrow
            logic box_ok;
            assign box_ok = &raw[REG_W-1:FW];
            assign val    = box_ok ? raw[FW-1:0] : CANON;
        end
    endgenerate
endmodule

// File: rtl/fpmm_class.sv
module fpmm_class #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [1+EXP_W+MAN_W-1:0] val,
    output logic                     is_nan,
    output logic                     is_snan,
    output logic                     is_zero,
    output logic                     sign
);
    localparam int FW = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign sign    = val[FW-1];
    assign exp_f   = val[FW-2:MAN_W];
    assign man_f   = val[MAN_W-1:0];
    assign is_nan  = (&exp_f) && (|man_f);
    assign is_snan = is_nan && !man_f[MAN_W-1];
    assign is_zero = (exp_f == '0) && (man_f == '0);
endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
    parameter int REG_W = 64,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [REG_W-1:0] a_raw,
    input  logic [REG_W-1:0] b_raw,
    input  logic             op_max,
    input  logic             nan_prop,
    output logic [REG_W-1:0] res_boxed,
    output logic             invalid
);
    localparam int FW = 1 + EXP_W + MAN_W;
    localparam logic [FW-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [FW-1:0] a_v, b_v, res;
    logic nan_a, nan_b, snan_a, snan_b, zero_a, zero_b, sgn_a, sgn_b;
    logic a_lt_b, a_le_b, b_le_a;

    fpmm_unbox #(.REG_W(REG_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_unbox_a (.raw(a_raw), .val(a_v));
    fpmm_unbox #(.REG_W(REG_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_unbox_b (.raw(b_raw), .val(b_v));

    fpmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class_a (
        .val(a_v), .is_nan(nan_a), .is_snan(snan_a), .is_zero(zero_a), .sign(sgn_a));
    fpmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class_b (
        .val(b_v), .is_nan(nan_b), .is_snan(snan_b), .is_zero(zero_b), .sign(sgn_b));

    // quiet ordering of two non-NaN values
    always_comb begin
        if (sgn_a != sgn_b) begin
            a_lt_b = sgn_a && !(zero_a && zero_b);
        end else if (!sgn_a) begin
            a_lt_b = a_v[FW-2:0] < b_v[FW-2:0];
        end else begin
            a_lt_b = a_v[FW-2:0] > b_v[FW-2:0];
        end
        a_le_b = a_lt_b || (a_v == b_v) || (zero_a && zero_b);
        b_le_a = !a_lt_b;
    end

    always_comb begin
        if (nan_a || nan_b) begin
            if (nan_prop || (nan_a && nan_b)) begin
                res = CANON;
            end else if (nan_a) begin
                res = b_v;
            end else begin
                res = a_v;
            end
        end else if (zero_a && zero_b && (sgn_a != sgn_b)) begin
            if (op_max) begin
                res = sgn_a ? b_v : a_v;
            end else begin
                res = sgn_a ? a_v : b_v;
            end
        end else if (op_max) begin
            res = b_le_a ? a_v : b_v;
        end else begin
            res = a_le_b ? a_v : b_v;
        end
    end

    generate
        if (REG_W == FW) begin : g_box_full
            assign res_boxed = res;
        end else begin : g_box_pad
            assign res_boxed = {{(REG_W-FW){1'b1}}, res};
        end
    endgenerate

    assign invalid = snan_a || snan_b;

    // lane-local checks on the selection against the classifiers
    always_comb begin
        if (!nan_prop && nan_a && !nan_b) begin
            p_numpref_b_r2: assert (res == b_v) else $error("number-preferring lost operand b");
        end
        if (!nan_a && !nan_b && zero_a && zero_b && (sgn_a != sgn_b)) begin
            p_zero_order_r5: assert (res[FW-1] == !op_max) else $error("signed zero order wrong");
        end
        if (!nan_a && !nan_b) begin
            p_pick_operand_r1: assert ((res == a_v) || (res == b_v)) else $error("result is neither operand");
        end
    end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
    parameter int REG_W = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [REG_W-1:0]            in_a,
    input  logic [REG_W-1:0]            in_b,
    input  logic                        in_op_max,
    input  logic                        in_nan_prop,
    input  logic [1:0]                  in_fmt,
    output logic                        out_valid,
    output logic [REG_W-1:0]            out_res,
    output logic [fpmm_pkg::FLAG_W-1:0] out_flags
);
    import fpmm_pkg::*;

    localparam int SEL_W = $clog2(NUM_FMT);

    typedef struct packed {
        logic              vld;
        logic [REG_W-1:0]  res;
        logic [FLAG_W-1:0] flags;
    } stage_t;

    stage_t st_d, st_q;

    logic [REG_W-1:0] lane_res [NUM_FMT];
    logic [NUM_FMT-1:0] lane_nv;
    logic [SEL_W-1:0] sel;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FMT; gi++) begin : g_lane
            fpmm_lane #(
                .REG_W(REG_W),
                .EXP_W(exp_bits(gi)),
                .MAN_W(man_bits(gi))
            ) u_lane (
                .a_raw    (in_a),
                .b_raw    (in_b),
                .op_max   (in_op_max),
                .nan_prop (in_nan_prop),
                .res_boxed(lane_res[gi]),
                .invalid  (lane_nv[gi])
            );
        end
    endgenerate

    always_comb begin
        case (fmt_e'(in_fmt))
            FMT_HALF:   sel = SEL_W'(0);
            FMT_SINGLE: sel = SEL_W'(1);
            default:    sel = SEL_W'(2);
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res            = lane_res[sel];
            st_d.flags          = '0;
            st_d.flags[FLAG_NV] = lane_nv[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_res   = st_q.res;
    assign out_flags = st_q.flags;

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid))
        else $error("out_valid does not track in_valid");

    p_boxed_half_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(in_fmt) == 2'd0) |-> (&out_res[REG_W-1:16]))
        else $error("half result not boxed");

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(out_res) && $stable(out_flags)))
        else $error("output changed while idle");

    p_flag_low_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_flags[FLAG_W-2:0] == '0))
        else $error("unexpected flag raised");
endmodule

// File: tb/sim_fp_minmax_unit.sv
module sim_fp_minmax_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic        in_op_max = 1'b0, in_nan_prop = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic        out_valid;
    logic [63:0] out_res;
    logic [4:0]  out_flags;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fp_minmax_unit #(.REG_W(64)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op_max(in_op_max), .in_nan_prop(in_nan_prop), .in_fmt(in_fmt),
        .out_valid(out_valid), .out_res(out_res), .out_flags(out_flags));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive one operation on a falling edge, sample on the next falling edge
    task automatic op(input logic [63:0] a, input logic [63:0] b, input logic mx,
                      input logic prop, input logic [1:0] f);
        @(negedge clk);
        in_a = a; in_b = b; in_op_max = mx; in_nan_prop = prop; in_fmt = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset res", out_res, 64'd0);
        chk("R9 reset flags", {59'd0, out_flags}, 64'd0);
    endtask

    task automatic t_basic;
        op(64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_40000000, 1'b0, 1'b0, 2'd1);
        chk("R1 single min", out_res, 64'hFFFFFFFF_3F800000);
        chk("R9 valid after op", {63'd0, out_valid}, 64'd1);
        op(64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_40000000, 1'b1, 1'b0, 2'd1);
        chk("R1 single max", out_res, 64'hFFFFFFFF_40000000);
        op(64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_3F800000, 1'b1, 1'b1, 2'd1);
        chk("R1 tie", out_res, 64'hFFFFFFFF_3F800000);
        @(negedge clk);
        chk("R9 valid drops", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_signs;
        op(64'hFFFFFFFF_FFFF3C00, 64'hFFFFFFFF_FFFFC000, 1'b0, 1'b0, 2'd0);
        chk("R6 half mixed min", out_res, 64'hFFFFFFFF_FFFFC000);
        op(64'hFFFFFFFF_FFFF3C00, 64'hFFFFFFFF_FFFFC000, 1'b1, 1'b0, 2'd0);
        chk("R6 half mixed max", out_res, 64'hFFFFFFFF_FFFF3C00);
        op(64'hBFF00000_00000000, 64'hC0080000_00000000, 1'b0, 1'b0, 2'd2);
        chk("R6 double neg min", out_res, 64'hC0080000_00000000);
        op(64'hBFF00000_00000000, 64'hC0080000_00000000, 1'b1, 1'b0, 2'd3);
        chk("R6 double neg max fmt3", out_res, 64'hBFF00000_00000000);
    endtask

    task automatic t_nan_pref;
        op(64'hFFFFFFFF_7FC00001, 64'hFFFFFFFF_3F800000, 1'b0, 1'b0, 2'd1);
        chk("R2 a nan", out_res, 64'hFFFFFFFF_3F800000);
        chk("R7 qnan no flag", {59'd0, out_flags}, 64'd0);
        op(64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_FFC00000, 1'b1, 1'b0, 2'd1);
        chk("R2 b nan", out_res, 64'hFFFFFFFF_3F800000);
        op(64'hFFFFFFFF_7FC00001, 64'hFFFFFFFF_FFC00005, 1'b0, 1'b0, 2'd1);
        chk("R3 single both nan", out_res, 64'hFFFFFFFF_7FC00000);
        op(64'h7FF00000_00000003, 64'hFFF80000_00000000, 1'b1, 1'b0, 2'd2);
        chk("R3 double both nan", out_res, 64'h7FF80000_00000000);
    endtask

    task automatic t_nan_prop;
        op(64'hFFFFFFFF_FFFF7E01, 64'hFFFFFFFF_FFFF3C00, 1'b0, 1'b1, 2'd0);
        chk("R4 half prop", out_res, 64'hFFFFFFFF_FFFF7E00);
        op(64'h3FF00000_00000000, 64'h7FF80000_00000001, 1'b1, 1'b1, 2'd2);
        chk("R4 double prop", out_res, 64'h7FF80000_00000000);
    endtask

    task automatic t_zeros;
        op(64'hFFFFFFFF_00000000, 64'hFFFFFFFF_80000000, 1'b0, 1'b0, 2'd1);
        chk("R5 min", out_res, 64'hFFFFFFFF_80000000);
        op(64'hFFFFFFFF_80000000, 64'hFFFFFFFF_00000000, 1'b1, 1'b0, 2'd1);
        chk("R5 max", out_res, 64'hFFFFFFFF_00000000);
        op(64'hFFFFFFFF_80000000, 64'hFFFFFFFF_00000000, 1'b0, 1'b1, 2'd1);
        chk("R5 min prop", out_res, 64'hFFFFFFFF_80000000);
        op(64'h00000000_00000000, 64'h80000000_00000000, 1'b1, 1'b1, 2'd2);
        chk("R5 max double", out_res, 64'h00000000_00000000);
    endtask

    task automatic t_flags;
        op(64'hFFFFFFFF_7F800001, 64'hFFFFFFFF_3F800000, 1'b0, 1'b0, 2'd1);
        chk("R7 snan res", out_res, 64'hFFFFFFFF_3F800000);
        chk("R7 snan flag", {59'd0, out_flags}, 64'h10);
        op(64'h3FF00000_00000000, 64'h7FF00000_00000001, 1'b0, 1'b1, 2'd2);
        chk("R7 snan prop flag", {59'd0, out_flags}, 64'h10);
        op(64'hFFFFFFFF_FFFF7C01, 64'hFFFFFFFF_FFFF3C00, 1'b1, 1'b0, 2'd0);
        chk("R7 half snan flag", {59'd0, out_flags}, 64'h10);
    endtask

    task automatic t_unbox;
        op(64'h00000000_3F800000, 64'hFFFFFFFF_40000000, 1'b0, 1'b0, 2'd1);
        chk("R8 bad box pref", out_res, 64'hFFFFFFFF_40000000);
        op(64'h00000000_3F800000, 64'hFFFFFFFF_40000000, 1'b0, 1'b1, 2'd1);
        chk("R8 bad box prop", out_res, 64'hFFFFFFFF_7FC00000);
        op(64'h00000000_7F800001, 64'hFFFFFFFF_40000000, 1'b0, 1'b0, 2'd1);
        chk("R8 bad box snan no flag", {59'd0, out_flags}, 64'd0);
        op(64'hFFFFFFFF_FFFF3C00, 64'hFFFFFFFF_0000C000, 1'b1, 1'b0, 2'd0);
        chk("R8 half bad box", out_res, 64'hFFFFFFFF_FFFF3C00);
    endtask

    task automatic t_hold;
        op(64'hFFFFFFFF_7F800001, 64'hFFFFFFFF_40000000, 1'b0, 1'b0, 2'd1);
        @(negedge clk);
        in_a = 64'hFFFFFFFF_00000000; in_b = 64'hFFFFFFFF_3F800000; in_fmt = 2'd1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 res held", out_res, 64'hFFFFFFFF_40000000);
        chk("R10 flags held", {59'd0, out_flags}, 64'h10);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        in_valid = 1'b1; in_a = 64'hFFFFFFFF_3F800000; in_b = 64'hFFFFFFFF_40000000;
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset wins valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset wins res", out_res, 64'd0);
        in_valid = 1'b0; rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_basic();
        t_signs();
        t_nan_pref();
        t_nan_prop();
        t_zeros();
        t_flags();
        t_unbox();
        t_hold();
        t_reset_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule